// File: doc/BRIEF.md
# Angle Conversion Sequencer

This block controls the measurement lifecycle of a rotary position sensor core. A front end that has already decoded serial frames hands it one command per cycle: start an angle conversion, soft reset, hard reset, or write the gain setting. For each accepted conversion the block leaves its low-power state and raises a busy flag. It also drives its active-low interrupt to the inactive level. It pulses a start strobe to the measurement datapath and waits for that datapath's done strobe.

When the done strobe arrives, the block latches a 14-bit result word. The word carries the angle and two field-strength alarm flags. The block then drops the busy flag, asserts the interrupt and returns to low power. Reset commands run a conversion of their own whose result is never written to the readable word.

A conversion that never completes is caught by a cycle counter. The counter puts the sequencer into a stuck state, and only a hard reset clears it. The gain setting either follows an external gain-loop value or is frozen at a written nonzero value. The effective gain is compared against two limits to form the alarm flags.

Top module: `angle_conv_seq`

## Requirements
- R1: After reset: busy=0, intN=1, lowPower=1, angleWord=0, agcSetting=0x20 and agcFrozen=0.
- R2: A start command (cmdKind=0) accepted while idle sets busy=1 and lowPower=0 in the next cycle, and drives intN=1. In that same cycle convStart is high for exactly one cycle.
- R3: In the cycle after convDone is seen during a conversion: busy=0, intN=0 (interrupt enabled) and lowPower=1. For a start command, angleWord[9:0] then holds convAngle and bits 11:10 are 0.
- R4: A start or soft-reset command that arrives while busy=1 produces no convStart and changes nothing. This includes a command that arrives in the same cycle as convDone.
- R5: The latched word sets bit 13 when the effective gain is at or above AGC_MAX (default 60). It sets bit 12 when the effective gain is at or below AGC_MIN (default 4). When convFail is high at completion, both bits are set.
- R6: A gain write (cmdKind=3, value in cmdData[5:0]) stores the value. A nonzero value sets agcFrozen=1, and the stored value then replaces agcLoop as the effective gain. A zero value clears agcFrozen, and agcLoop is the effective gain again.
- R7: A soft reset (cmdKind=1) accepted while idle runs a conversion that leaves angleWord unchanged. If cmdData[2]=1, it also pulses spiRegReset and restores agcSetting=0x20 with agcFrozen=0. If cmdData[2]=0, the gain state is kept.
- R8: A hard reset (cmdKind=2) is accepted in any state. It clears angleWord to 0, restores the gain defaults, pulses spiRegReset and starts a hidden conversion.
- R9: If no convDone arrives within TIMEOUT_CYC cycles of a start, busy stays 1 and intN stays 1. Later convDone pulses and start commands are ignored until a hard reset.
- R10: While intEnN=1, intN is 1 regardless of conversion state.
- R11: A hard reset in the same cycle as convDone discards that result. The cycle after, angleWord=0, busy=1 and convStart=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe from the serial front end |
| cmdKind | input | 2 | 0 start, 1 soft reset, 2 hard reset, 3 gain write |
| cmdData | input | 14 | Command data word (gain value in 5:0, register-reset flag in bit 2) |
| intEnN | input | 1 | Active-low interrupt enable |
| agcLoop | input | 6 | Gain value from the automatic gain loop |
| convDone | input | 1 | Measurement datapath completion strobe |
| convAngle | input | 10 | Angle from the measurement datapath |
| convFail | input | 1 | Measurement datapath system error |
| convStart | output | 1 | One-cycle conversion start strobe |
| busy | output | 1 | Conversion in progress or stuck |
| intN | output | 1 | Active-low result-ready interrupt |
| lowPower | output | 1 | Low-power state indicator |
| spiRegReset | output | 1 | One-cycle pulse resetting the serial register set |
| angleWord | output | 14 | Alarm Lo (13), Alarm Hi (12), angle (9:0) |
| agcSetting | output | 6 | Stored gain register |
| agcFrozen | output | 1 | Gain loop frozen at agcSetting |

## Verification
Two pairs of events can land in the same cycle: completion together with a new start command, and completion together with a hard reset. The bench drives convDone and the command strobe on the same clock edge in each case. For the first pair, it judges the outcome by requiring that busy falls with no new convStart and that the scoreboard receives the measured word. For the second, it requires that busy stays high, convStart fires again and the word reads zero. The stuck state is reached by withholding convDone past the timeout. A late done strobe then has to be shown to have no effect.

// File: rtl/acs_pkg.sv
package acs_pkg;

  typedef enum logic [1:0] {
    CMD_START      = 2'd0,
    CMD_SOFT_RST   = 2'd1,
    CMD_HARD_RST   = 2'd2,
    CMD_GAIN_WRITE = 2'd3
  } cmdKind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_STUCK = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchResult;
    logic clearResult;
    logic resetGain;
  } ctlStrobe_t;

endpackage

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  cmdKind_t   cmdKind,
  input  logic       regResetFlag,
  input  logic       convDone,
  output logic       convStart,
  output logic       busy,
  output logic       intLevel,
  output logic       lowPower,
  output logic       spiRegReset,
  output ctlStrobe_t strobe
);

  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  seqState_t        state;
  logic             hiddenQ;
  logic [TMR_W-1:0] timer;

  logic startCmd, softCmd, hardCmd;
  logic startOk, softOk, anyStart, doneOk, timeoutHit;

  always_comb begin
    startCmd   = cmdValid && (cmdKind == CMD_START);
    softCmd    = cmdValid && (cmdKind == CMD_SOFT_RST);
    hardCmd    = cmdValid && (cmdKind == CMD_HARD_RST);
    startOk    = startCmd && (state == ST_IDLE);
    softOk     = softCmd  && (state == ST_IDLE);
    anyStart   = hardCmd || startOk || softOk;
    doneOk     = (state == ST_CONV) && convDone && !hardCmd;
    timeoutHit = (state == ST_CONV) && !convDone &&
                 (timer == TMR_W'(TIMEOUT_CYC - 1));
    strobe.latchResult = doneOk && !hiddenQ;
    strobe.clearResult = hardCmd;
    strobe.resetGain   = hardCmd || (softOk && regResetFlag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      hiddenQ     <= 1'b0;
      timer       <= '0;
      busy        <= 1'b0;
      intLevel    <= 1'b1;
      lowPower    <= 1'b1;
      convStart   <= 1'b0;
      spiRegReset <= 1'b0;
    end else begin
      convStart   <= anyStart;
      spiRegReset <= hardCmd || (softOk && regResetFlag);
      if (anyStart) begin
        state    <= ST_CONV;
        hiddenQ  <= !startOk;
        timer    <= '0;
        busy     <= 1'b1;
        intLevel <= 1'b1;
        lowPower <= 1'b0;
      end else if (doneOk) begin
        state    <= ST_IDLE;
        busy     <= 1'b0;
        intLevel <= 1'b0;
        lowPower <= 1'b1;
      end else if (timeoutHit) begin
        state <= ST_STUCK;
      end else if (state == ST_CONV) begin
        timer <= timer + 1'b1;
      end
    end
  end

  AST_START_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);  // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    ((startCmd || softCmd) && state != ST_IDLE) |=> !convStart);  // R4
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |=> (!busy && !intLevel && lowPower));  // R3
  AST_STUCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STUCK && !hardCmd) |=> (busy && intLevel && state == ST_STUCK));  // R9
  AST_HARD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    hardCmd |=> (convStart && busy && spiRegReset));  // R8

endmodule

// File: rtl/acs_dpath.sv
module acs_dpath
  import acs_pkg::*;
#(
  parameter int ANGLE_W  = 10,
  parameter int AGC_W    = 6,
  parameter int AGC_MIN  = 4,
  parameter int AGC_MAX  = 60,
  parameter int AGC_INIT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic                 gainWrEn,
  input  logic [AGC_W-1:0]     gainWrVal,
  input  logic [AGC_W-1:0]     agcLoop,
  input  logic [ANGLE_W-1:0]   convAngle,
  input  logic                 convFail,
  output logic [ANGLE_W+3:0]   angleWord,
  output logic [AGC_W-1:0]     agcSetting,
  output logic                 agcFrozen
);

  localparam int WORD_W = ANGLE_W + 4;
  localparam int GAP_W  = WORD_W - ANGLE_W - 2;

  logic [AGC_W-1:0] gainEff;
  logic             alarmWeak, alarmStrong;

  always_comb begin
    gainEff     = agcFrozen ? agcSetting : agcLoop;
    alarmWeak   = convFail || (gainEff >= AGC_W'(AGC_MAX));
    alarmStrong = convFail || (gainEff <= AGC_W'(AGC_MIN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      agcSetting <= AGC_W'(AGC_INIT);
      agcFrozen  <= 1'b0;
      angleWord  <= '0;
    end else begin
      if (strobe.resetGain) begin
        agcSetting <= AGC_W'(AGC_INIT);
        agcFrozen  <= 1'b0;
      end else if (gainWrEn) begin
        agcSetting <= gainWrVal;
        agcFrozen  <= (gainWrVal != '0);
      end
      if (strobe.clearResult)
        angleWord <= '0;
      else if (strobe.latchResult)
        angleWord <= {alarmWeak, alarmStrong, {GAP_W{1'b0}}, convAngle};
    end
  end

  AST_FROZEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    agcFrozen |-> (agcSetting != '0));  // R6
  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearResult |=> (angleWord == '0));  // R8
  AST_HIDDEN_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.latchResult && !strobe.clearResult) |=> $stable(angleWord));  // R7
  AST_GAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchResult |=> (angleWord[WORD_W-3:ANGLE_W] == '0));  // R3

endmodule

// File: rtl/angle_conv_seq.sv
module angle_conv_seq
  import acs_pkg::*;
#(
  parameter int ANGLE_W     = 10,
  parameter int AGC_W       = 6,
  parameter int AGC_MIN     = 4,
  parameter int AGC_MAX     = 60,
  parameter int AGC_INIT    = 32,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdKind,
  input  logic [ANGLE_W+3:0] cmdData,
  input  logic               intEnN,
  input  logic [AGC_W-1:0]   agcLoop,
  input  logic               convDone,
  input  logic [ANGLE_W-1:0] convAngle,
  input  logic               convFail,
  output logic               convStart,
  output logic               busy,
  output logic               intN,
  output logic               lowPower,
  output logic               spiRegReset,
  output logic [ANGLE_W+3:0] angleWord,
  output logic [AGC_W-1:0]   agcSetting,
  output logic               agcFrozen
);

  localparam int REG_RST_BIT = 2;

  cmdKind_t   kindT;
  ctlStrobe_t strobe;
  logic       intLevel;
  logic       gainWrEn;

  assign kindT    = cmdKind_t'(cmdKind);
  assign gainWrEn = cmdValid && (kindT == CMD_GAIN_WRITE);
  assign intN     = intEnN | intLevel;

  acs_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdKind      (kindT),
    .regResetFlag (cmdData[REG_RST_BIT]),
    .convDone     (convDone),
    .convStart    (convStart),
    .busy         (busy),
    .intLevel     (intLevel),
    .lowPower     (lowPower),
    .spiRegReset  (spiRegReset),
    .strobe       (strobe)
  );

  acs_dpath #(
    .ANGLE_W (ANGLE_W), .AGC_W (AGC_W), .AGC_MIN (AGC_MIN),
    .AGC_MAX (AGC_MAX), .AGC_INIT (AGC_INIT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .gainWrEn   (gainWrEn),
    .gainWrVal  (cmdData[AGC_W-1:0]),
    .agcLoop    (agcLoop),
    .convAngle  (convAngle),
    .convFail   (convFail),
    .angleWord  (angleWord),
    .agcSetting (agcSetting),
    .agcFrozen  (agcFrozen)
  );

endmodule

// File: tb/tb_angle_conv_seq.sv
module tb_angle_conv_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdKind = 2'd0;
  logic [13:0] cmdData = '0;
  logic        intEnN = 1'b0;
  logic [5:0]  agcLoop = 6'd30;
  logic        convDone = 1'b0;
  logic [9:0]  convAngle = '0;
  logic        convFail = 1'b0;
  logic        convStart, busy, intN, lowPower, spiRegReset, agcFrozen;
  logic [13:0] angleWord;
  logic [5:0]  agcSetting;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [13:0] expQ[$];
  logic [13:0] lastWord = '0;
  logic        prevBusy = 1'b0;

  always #10 clk = ~clk;

  angle_conv_seq dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdData(cmdData), .intEnN(intEnN), .agcLoop(agcLoop),
    .convDone(convDone), .convAngle(convAngle), .convFail(convFail),
    .convStart(convStart), .busy(busy), .intN(intN), .lowPower(lowPower),
    .spiRegReset(spiRegReset), .angleWord(angleWord),
    .agcSetting(agcSetting), .agcFrozen(agcFrozen)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every falling edge of busy pops one expected result word
  always @(negedge clk) begin
    if (rstN && prevBusy && !busy) begin
      if (expQ.size() == 0) check(0, "R3 unexpected completion", angleWord, 0);
      else begin
        logic [13:0] e;
        e = expQ.pop_front();
        check(angleWord == e, "R3/R5/R7 scoreboard word", angleWord, e);
      end
    end
    prevBusy = busy;
  end

  task automatic sendCmd(input logic [1:0] k, input logic [13:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = k; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finishConv(input logic [9:0] a, input bit f, input int dly);
    repeat (dly) @(negedge clk);
    convDone = 1'b1; convAngle = a; convFail = f;
    @(negedge clk);
    convDone = 1'b0; convFail = 1'b0;
  endtask

  // driver: start a conversion and push the word the requirements predict
  task automatic readAngle(input logic [9:0] a, input bit f, input bit lo, input bit hi);
    logic [13:0] e;
    e = {lo, hi, 2'b00, a};
    sendCmd(2'd0, '0);
    expQ.push_back(e);
    finishConv(a, f, 3);
    lastWord = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..R11 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(intN == 1, "R1 intN", intN, 1);
    check(lowPower == 1, "R1 lowPower", lowPower, 1);
    check(angleWord == 0, "R1 angleWord", angleWord, 0);
    check(agcSetting == 6'h20 && !agcFrozen, "R1 gain", agcSetting, 6'h20);

    // R2 start handshake
    sendCmd(2'd0, '0);
    check(convStart == 1, "R2 convStart", convStart, 1);
    check(busy == 1 && intN == 1 && lowPower == 0, "R2 busy/int/lp", {busy, intN, lowPower}, 3'b110);
    expQ.push_back({4'b0000, 10'h155});
    @(negedge clk);
    check(convStart == 0, "R2 start pulse width", convStart, 0);
    finishConv(10'h155, 0, 2);
    lastWord = {4'b0000, 10'h155};
    // R3 release
    check(busy == 0 && intN == 0 && lowPower == 1, "R3 release", {busy, intN, lowPower}, 3'b001);

    // R5 alarm boundaries
    agcLoop = 6'd60; readAngle(10'h3FF, 0, 1, 0);
    agcLoop = 6'd4;  readAngle(10'h001, 0, 0, 1);
    agcLoop = 6'd59; readAngle(10'h222, 0, 0, 0);
    agcLoop = 6'd5;  readAngle(10'h123, 0, 0, 0);
    agcLoop = 6'd30; readAngle(10'h0F0, 1, 1, 1);

    // R4 start while busy ignored
    sendCmd(2'd0, '0);
    sendCmd(2'd0, '0);
    check(convStart == 0, "R4 second start", convStart, 0);
    sendCmd(2'd1, 14'h0004);
    check(convStart == 0 && spiRegReset == 0, "R4 soft while busy", {convStart, spiRegReset}, 0);
    expQ.push_back({4'b0000, 10'h0AB});
    finishConv(10'h0AB, 0, 1);
    lastWord = {4'b0000, 10'h0AB};

    // R4 start colliding with completion
    sendCmd(2'd0, '0);
    expQ.push_back({4'b0000, 10'h2C3});
    @(negedge clk);
    convDone = 1'b1; convAngle = 10'h2C3; cmdValid = 1'b1; cmdKind = 2'd0;
    @(negedge clk);
    convDone = 1'b0; cmdValid = 1'b0;
    lastWord = {4'b0000, 10'h2C3};
    check(busy == 0 && convStart == 0, "R4 collision ignored", {busy, convStart}, 0);

    // R6 gain freeze
    sendCmd(2'd3, 14'd62);
    check(agcSetting == 62 && agcFrozen == 1, "R6 freeze", {agcFrozen, agcSetting}, {1'b1, 6'd62});
    readAngle(10'h011, 0, 1, 0);
    sendCmd(2'd3, 14'd0);
    check(agcFrozen == 0, "R6 unfreeze", agcFrozen, 0);
    readAngle(10'h012, 0, 0, 0);

    // R7 soft reset with register reset
    sendCmd(2'd3, 14'd10);
    sendCmd(2'd1, 14'h0004);
    check(spiRegReset == 1 && busy == 1, "R7 reg reset pulse", {spiRegReset, busy}, 2'b11);
    check(agcSetting == 6'h20 && agcFrozen == 0, "R7 gain default", agcSetting, 6'h20);
    expQ.push_back(lastWord);
    finishConv(10'h0AA, 0, 2);
    check(angleWord == lastWord, "R7 word unchanged", angleWord, lastWord);
    // R7 soft reset without register reset
    sendCmd(2'd3, 14'd10);
    sendCmd(2'd1, 14'h0000);
    check(spiRegReset == 0 && agcFrozen == 1 && agcSetting == 10, "R7 gain kept", agcSetting, 10);
    expQ.push_back(lastWord);
    finishConv(10'h0BB, 0, 2);
    sendCmd(2'd3, 14'd0);

    // R10 interrupt enable
    intEnN = 1'b1;
    @(negedge clk);
    check(intN == 1, "R10 disabled", intN, 1);
    intEnN = 1'b0;
    @(negedge clk);
    check(intN == 0, "R10 enabled", intN, 0);

    // R9 timeout into stuck state
    sendCmd(2'd0, '0);
    repeat (300) @(negedge clk);
    check(busy == 1 && intN == 1, "R9 stuck", {busy, intN}, 2'b11);
    finishConv(10'h3AA, 0, 0);
    check(busy == 1 && angleWord == lastWord, "R9 late done ignored", angleWord, lastWord);
    sendCmd(2'd0, '0);
    check(convStart == 0, "R9 start ignored", convStart, 0);

    // R8 hard reset escapes
    sendCmd(2'd2, '0);
    check(convStart == 1 && busy == 1 && angleWord == 0 && spiRegReset == 1, "R8 hard reset",
          {convStart, busy, spiRegReset, angleWord}, {3'b111, 14'h0});
    expQ.push_back(14'h0);
    finishConv(10'h155, 0, 2);
    lastWord = '0;
    check(busy == 0, "R8 hidden done", busy, 0);

    // R11 hard reset colliding with completion
    readAngle(10'h0C4, 0, 0, 0);
    sendCmd(2'd0, '0);
    @(negedge clk);
    convDone = 1'b1; convAngle = 10'h3C3; cmdValid = 1'b1; cmdKind = 2'd2;
    @(negedge clk);
    convDone = 1'b0; cmdValid = 1'b0;
    check(busy == 1 && convStart == 1 && angleWord == 0, "R11 hard wins",
          {busy, convStart, angleWord}, {2'b11, 14'h0});
    expQ.push_back(14'h0);
    finishConv(10'h111, 0, 2);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule